// File: doc/BRIEF.md
# Pipelined SEC-DED Memory Word Protection

This block protects a 64-bit memory data word with 8 check bits built from an extended Hamming (72,64) code. It has a write side and a read side. On the write side the check bits are a purely combinational function of the outgoing word, so they leave in the same cycle as the data. On the read side the incoming word and its check bits are captured in one register stage. The syndrome is then computed, any single-bit error is repaired, and the result comes out one clock after it arrived. It carries a flag for a repaired single-bit error, a flag for a detected but uncorrectable double-bit error, and the raw syndrome for error logging.

A mode input turns protection off. In that mode the read word takes a bypass with no register stage. It arrives at the output in the same cycle, with both error flags and the syndrome held at zero. Merging partial writes and raising interrupts belong to surrounding logic.

Top module: `ecc72_path`

## Requirements
- R1: The Hamming positions 1 to 71 hold the code word. The powers of two (1,2,4,...,64) hold the parity bits, and the 64 data bits fill the remaining positions in ascending order (data bit 0 at position 3, bit 1 at 5, bit 2 at 6, bit 3 at 7, bit 4 at 9, ...). wr_check[i] for i in 0..6 is the XOR of the data bits whose position has bit i set. wr_check[7] is the XOR of all 64 data bits and wr_check[6:0]. wr_check follows wr_data in the same cycle.
- R2: With ecc_on high, rd_valid_out equals rd_valid_in delayed by exactly one clock, and the data, flags and syndrome of a read appear in that same later cycle.
- R3: A read word whose check bits match its data gives rd_data_out equal to rd_data_in, both flags low and syndrome zero.
- R4: A single flipped bit anywhere in the 72 stored bits is repaired on rd_data_out, with sbe_flag high and dbe_flag low. The syndrome is {1, p}, where p is the flipped bit's Hamming position, or p = 0 when wr_check[7] is the flipped bit.
- R5: Two flipped bits give dbe_flag high and sbe_flag low. rd_data_out then carries the received data unchanged, and the syndrome is {0, p1 XOR p2}.
- R6: sbe_flag and dbe_flag are never high together, and neither is high unless rd_valid_out is high.
- R7: With ecc_on low, rd_valid_out and rd_data_out equal rd_valid_in and rd_data_in in the same cycle. Both flags stay low and the syndrome stays zero, even for a corrupted word.
- R8: After reset, rd_valid_out and both flags are low until a valid read has passed the register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ecc_on | input | 1 | 1: check and correct with one cycle latency; 0: zero-latency bypass |
| wr_data | input | 64 | Word being written |
| wr_check | output | 8 | Check bits for wr_data, same cycle |
| rd_valid_in | input | 1 | Read word present |
| rd_data_in | input | 64 | Read data from memory |
| rd_check_in | input | 8 | Read check bits from memory |
| rd_valid_out | output | 1 | Delivered word valid |
| rd_data_out | output | 64 | Delivered (corrected) word |
| sbe_flag | output | 1 | Single-bit error was corrected |
| dbe_flag | output | 1 | Uncorrectable double-bit error |
| syndrome | output | 8 | {overall parity error, 7-bit Hamming syndrome} |

## Verification
The assertions assume that ecc_on changes only while no read is in the register stage. This is because the output multiplexer switches on the current mode, and a mode change would otherwise reinterpret a captured word. The stimulus changes mode only after an idle read has been captured. The loopback property also assumes that read data equal to wr_data with the check bits from wr_check stands for a clean word. The bench drives wr_data with the uncorrupted word on every read, so that relation holds.

// File: rtl/ecc72_path.sv
`timescale 1ns/1ps
module ecc72_path #(
  parameter int DW = 64,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ecc_on,
  input  logic [DW-1:0] wr_data,
  output logic [CW-1:0] wr_check,
  input  logic          rd_valid_in,
  input  logic [DW-1:0] rd_data_in,
  input  logic [CW-1:0] rd_check_in,
  output logic          rd_valid_out,
  output logic [DW-1:0] rd_data_out,
  output logic          sbe_flag,
  output logic          dbe_flag,
  output logic [CW-1:0] syndrome
);
  localparam int PB   = CW - 1;
  localparam int NPOS = DW + PB;

  function automatic int pos_of(input int d);
    int k;
    k = -1;
    for (int p = 1; p <= NPOS; p++) begin
      if ((p & (p - 1)) != 0) begin
        k++;
        if (k == d) return p;
      end
    end
    return 0;
  endfunction

  function automatic logic [DW-1:0] mask_of(input int i);
    logic [DW-1:0] m;
    m = '0;
    for (int d = 0; d < DW; d++)
      m[d] = ((pos_of(d) >> i) & 1) == 1;
    return m;
  endfunction

  logic          v_q;
  logic [DW-1:0] data_q;
  logic [CW-1:0] chk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= 1'b0;
    else        v_q <= rd_valid_in;
  end

  always_ff @(posedge clk) begin
    data_q <= rd_data_in;
    chk_q  <= rd_check_in;
  end

  logic [PB-1:0] enc_par, dec_par, syn;
  logic [DW-1:0] flip;

  for (genvar i = 0; i < PB; i++) begin : g_par
    localparam logic [DW-1:0] M = mask_of(i);
    assign enc_par[i] = ^(wr_data & M);
    assign dec_par[i] = ^(data_q & M);
  end

  assign wr_check = {^{wr_data, enc_par}, enc_par};

  assign syn = dec_par ^ chk_q[PB-1:0];

  logic ovf, in_range, single, dbl, live;
  assign ovf      = ^{data_q, chk_q};
  assign in_range = int'(syn) <= NPOS;
  assign single   = ovf && in_range;
  assign dbl      = (!ovf && syn != '0) || (ovf && !in_range);
  assign live     = ecc_on && v_q;

  for (genvar d = 0; d < DW; d++) begin : g_fix
    localparam int P = pos_of(d);
    assign flip[d] = single && (syn == PB'(P));
  end

  assign rd_valid_out = ecc_on ? v_q : rd_valid_in;
  assign rd_data_out  = ecc_on ? (data_q ^ flip) : rd_data_in;
  assign sbe_flag     = live && single;
  assign dbe_flag     = live && dbl;
  assign syndrome     = live ? {ovf, syn} : '0;
endmodule

module ecc72_path_chk #(
  parameter int DW = 64,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ecc_on,
  input logic [DW-1:0] wr_data,
  input logic [CW-1:0] wr_check,
  input logic          rd_valid_in,
  input logic [DW-1:0] rd_data_in,
  input logic [CW-1:0] rd_check_in,
  input logic          rd_valid_out,
  input logic [DW-1:0] rd_data_out,
  input logic          sbe_flag,
  input logic          dbe_flag,
  input logic [CW-1:0] syndrome
);
  // R2
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ecc_on && rd_valid_in) |=> (!ecc_on || rd_valid_out));

  // R3
  clean_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ecc_on && rd_valid_in && rd_data_in == wr_data && rd_check_in == wr_check)
    |=> (!ecc_on || (!sbe_flag && !dbe_flag && rd_data_out == $past(rd_data_in))));

  // R6
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sbe_flag && dbe_flag));

  // R6
  flag_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sbe_flag || dbe_flag) |-> rd_valid_out);

  // R7
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ecc_on |-> (rd_valid_out == rd_valid_in && rd_data_out == rd_data_in
                 && !sbe_flag && !dbe_flag && syndrome == '0));

  // R8
  reset_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (!sbe_flag && !dbe_flag && (!ecc_on || !rd_valid_out)));
endmodule

bind ecc72_path ecc72_path_chk #(.DW(DW), .CW(CW)) u_chk (.*);

// File: tb/sim_ecc72_path.sv
`timescale 1ns/1ps
module sim_ecc72_path;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ecc_on = 1'b1;
  logic [63:0] wr_data = '0;
  logic [7:0]  wr_check;
  logic        rd_valid_in = 1'b0;
  logic [63:0] rd_data_in = '0;
  logic [7:0]  rd_check_in = '0;
  logic        rd_valid_out;
  logic [63:0] rd_data_out;
  logic        sbe_flag, dbe_flag;
  logic [7:0]  syndrome;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  ecc72_path u0 (.*);

  // reference code word: bit 0 = overall parity, bits 1..71 = Hamming positions
  function automatic logic [71:0] pack(input logic [63:0] d, input logic [7:0] c);
    logic [71:0] w;
    int j;
    w = '0; j = 0;
    for (int p = 1; p < 72; p++) begin
      if ((p & (p - 1)) == 0) w[p] = c[$clog2(p)];
      else begin w[p] = d[j]; j++; end
    end
    w[0] = c[7];
    return w;
  endfunction

  function automatic logic [63:0] unpack_d(input logic [71:0] w);
    logic [63:0] d;
    int j;
    j = 0;
    for (int p = 1; p < 72; p++)
      if ((p & (p - 1)) != 0) begin d[j] = w[p]; j++; end
    return d;
  endfunction

  function automatic logic [7:0] unpack_c(input logic [71:0] w);
    logic [7:0] c;
    for (int i = 0; i < 7; i++) c[i] = w[1 << i];
    c[7] = w[0];
    return c;
  endfunction

  function automatic logic [7:0] ref_enc(input logic [63:0] d);
    logic [71:0] w;
    logic [7:0] c;
    w = pack(d, 8'h00);
    c = '0;
    for (int p = 1; p < 72; p++)
      if (w[p]) c[6:0] = c[6:0] ^ 7'(p);
    for (int i = 0; i < 7; i++) w[1 << i] = c[i];
    c[7] = ^w[71:1];
    return c;
  endfunction

  task automatic cmp(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  logic        p_on = 1'b0;
  logic        e_v;
  logic [63:0] e_d;
  logic        e_s, e_e;
  logic [7:0]  e_syn;
  string       e_req;

  task automatic check_out();
    cmp(e_req, "valid", 64'(rd_valid_out), 64'(e_v));
    if (e_v) begin
      cmp(e_req, "data", rd_data_out, e_d);
      cmp(e_req, "sbe", 64'(sbe_flag), 64'(e_s));
      cmp(e_req, "dbe", 64'(dbe_flag), 64'(e_e));
      cmp(e_req, "syndrome", 64'(syndrome), 64'(e_syn));
    end
  endtask

  task automatic step(input logic v, input logic [63:0] clean, input logic [71:0] flips,
                      input logic [63:0] xd, input logic xs, input logic xe,
                      input logic [7:0] xsyn, input string req);
    logic [71:0] w;
    @(negedge clk);
    if (p_on) check_out();
    p_on = 1'b0;
    w = pack(clean, ref_enc(clean)) ^ flips;
    wr_data     = clean;
    rd_valid_in = v;
    rd_data_in  = unpack_d(w);
    rd_check_in = unpack_c(w);
    e_v = v; e_d = xd; e_s = xs; e_e = xe; e_syn = xsyn; e_req = req;
    #1;
    cmp("R1", "wr_check", 64'(wr_check), 64'(ref_enc(clean)));
    if (!ecc_on) check_out();
    else p_on = 1'b1;
  endtask

  task automatic set_mode(input logic m);
    step(1'b0, '0, '0, '0, 1'b0, 1'b0, '0, "R2");
    @(negedge clk);
    if (p_on) check_out();
    p_on = 1'b0;
    ecc_on = m;
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] d;
    logic [71:0] f;
    int a, b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8
    cmp("R8", "valid after reset", 64'(rd_valid_out), 64'd0);
    cmp("R8", "flags after reset", 64'({sbe_flag, dbe_flag}), 64'd0);

    // R1, R3: clean words including extremes
    step(1'b1, '0, '0, '0, 1'b0, 1'b0, '0, "R3");
    step(1'b1, '1, '0, '1, 1'b0, 1'b0, '0, "R3");
    for (int k = 0; k < 20; k++) begin
      d = {$urandom, $urandom};
      step(1'b1, d, '0, d, 1'b0, 1'b0, '0, "R3");
    end
    // R2: idle gap yields no valid
    step(1'b0, '0, '0, '0, 1'b0, 1'b0, '0, "R2");

    // R4: every single position, including check bits
    for (int k = 0; k < 72; k++) begin
      d = {$urandom, $urandom};
      f = '0; f[k] = 1'b1;
      step(1'b1, d, f, d, 1'b1, 1'b0, {1'b1, 7'(k)}, "R4");
    end

    // R5: random double pairs
    for (int k = 0; k < 300; k++) begin
      logic [71:0] w;
      d = {$urandom, $urandom};
      a = int'($urandom % 72);
      b = int'($urandom % 71);
      if (b >= a) b++;
      f = '0; f[a] = 1'b1; f[b] = 1'b1;
      w = pack(d, ref_enc(d)) ^ f;
      step(1'b1, d, f, unpack_d(w), 1'b0, 1'b1, {1'b0, 7'(a ^ b)}, "R5");
      if (k % 7 == 0) step(1'b0, '0, '0, '0, 1'b0, 1'b0, '0, "R2");
    end

    // R7: bypass with corrupted and clean words
    set_mode(1'b0);
    for (int k = 0; k < 30; k++) begin
      logic [71:0] w;
      d = {$urandom, $urandom};
      f = '0; f[$urandom % 72] = 1'b1;
      if (k % 2 == 0) f[($urandom % 71) + 1] ^= 1'b1;
      w = pack(d, ref_enc(d)) ^ f;
      step(k % 5 != 4, d, f, unpack_d(w), 1'b0, 1'b0, '0, "R7");
    end

    // R2: back to corrected mode
    set_mode(1'b1);
    for (int k = 0; k < 10; k++) begin
      d = {$urandom, $urandom};
      f = '0; f[k * 7] = 1'b1;
      step(1'b1, d, f, d, 1'b1, 1'b0, {1'b1, 7'(k * 7)}, "R2");
    end
    step(1'b0, '0, '0, '0, 1'b0, 1'b0, '0, "R2");
    @(negedge clk);
    if (p_on) check_out();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule